// File: doc/BRIEF.md
# Sensor SPI Slave Frame Engine

This block is a 16-bit SPI slave in mode 0. An active-low select frames each transfer. While a frame is open, the block samples MOSI on SCK rising edges and builds the incoming request. At the same time it shifts out on MISO, MSB first, the reply it computed when the previous frame closed. A new reply is loaded at the end of every frame, so each answer appears one frame after its request.

Request bit 13 chooses between two kinds of request. When it is set, the request reads one byte of a sampled x or y acceleration word, and the low nibble picks the axis and the byte. When it is clear, the request reads or writes the single 8-bit control register, which is also driven out of the block. The block counts SCK rising edges in each frame. A frame with the wrong count is not executed and produces a clock-error reply. Undefined requests produce a request-error reply. A sensor read while the part is powered down or the heater loop is out of regulation produces a fault reply. Every reply has odd parity over all 16 bits. All SPI pins pass through synchronisers into the system clock, and the block expects SCK to be slow relative to that clock.

Top module: `spi_sensor_frame`

## Requirements
- R1: A frame runs from the falling edge of sel_n to its rising edge. MOSI is sampled on SCK rising edges. MISO presents the reply MSB first and moves to the next bit on each SCK falling edge. MISO is 0 while sel_n is high.
- R2: The reply shifted out during frame N+1 is the answer to the request received in frame N.
- R3: The first frame after reset returns 16'h0E03. This is a status reply with opcode 00 and data byte 8'h03, meaning request-error (bit 1) and data-unavailable (bit 0) are set.
- R4: A status reply is laid out as follows: bit 15 = 0, bits 14:13 = opcode echoed from request bits 15:14, bit 12 = parity, bits 11:10 = 2'b11, bits 9:8 = 2'b10, bits 7:0 = data.
- R5: Bit 12 of every reply is set so that the 16-bit reply word has an odd number of ones.
- R6: A sensor read (bit 13 = 1) with channel bits 3:0 equal to 0, 1, 2 or 3 returns the low byte of x, the high byte of x, the low byte of y or the high byte of y, in that order of channel code. The reply is laid out as follows: bits 15:14 = request bits 15:14, bit 13 = 1, bit 12 = parity, bit 11 = request bit 12, bits 10:8 = channel bits 2:0, bits 7:0 = the selected byte. Request bits 11:4 have no effect.
- R7: A request with bit 13 = 0 and bits 15:14 = 01 writes request bits 7:0 into the control register. The status reply carries opcode 01 and the new value. Request bits 12:8 have no effect.
- R8: A request with bit 13 = 0 and bits 15:14 = 10 returns a status reply with opcode 10 and the current control register value. The register is not changed.
- R9: A request with bit 13 = 0 and opcode 00 or 11, or a sensor read with a channel code from 4 to 15, is illegal. It returns a status reply that echoes request bits 15:14 as the opcode and carries data 8'h02. The control register is not changed.
- R10: A frame whose SCK rising-edge count is not 16 is not executed. The control register is not changed, and the next reply is a status reply with opcode 00 and data 8'h04.
- R11: A legal sensor read while pwr_down or heat_fault is high returns a status reply with the request opcode, data bit 4 = pwr_down and data bit 3 = heat_fault. The error priority is clock error, then illegal request, then sensor fault.
- R12: Reset clears the control register to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI clock from the master |
| mosi | input | 1 | Serial request data in |
| x_word | input | 16 | Sampled x-axis acceleration word |
| y_word | input | 16 | Sampled y-axis acceleration word |
| pwr_down | input | 1 | Part is in power-down |
| heat_fault | input | 1 | Heater regulation loop fault |
| miso | output | 1 | Serial reply data out |
| ctrl_reg | output | 8 | Control register contents |

## Verification
The bench sweeps all sixteen channel codes and all four fault-flag combinations. It writes and reads back sixteen register values and sends both undefined opcodes. It also sends frames with 0, 15 and 17 clock edges. Each of these cases targets a specific way the design could fail:
- A design that forgot the one-frame delay would return each answer in the same frame, and every comparison would be off by one request.
- A design with the wrong channel decode would return the wrong byte or would accept codes 4 to 15.
- A design that executed short or long frames would change the register on a bad write and would not report the 8'h04 clock error.
- A wrong parity polarity would fail every reply word.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int NUM_CH     = 4;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_BAD  = 2'b11
    } op_e;

    // error/status byte bit positions
    localparam int EB_PD = 4;
    localparam int EB_HE = 3;
    localparam int EB_SE = 2;
    localparam int EB_RE = 1;
    localparam int EB_DU = 0;

    typedef struct packed {
        logic       zero;
        logic [1:0] op;
        logic       par;
        logic [1:0] st;
        logic [1:0] es;
        logic [7:0] data;
    } stat_reply_t;

    typedef struct packed {
        logic [1:0] seq_hi;
        logic       sen;
        logic       par;
        logic       seq_lo;
        logic [2:0] ch;
        logic [7:0] data;
    } sens_reply_t;

    function automatic logic [15:0] seal_parity(input logic [15:0] w);
        logic [15:0] r;
        r     = w;
        r[12] = ~^{w[15:13], w[11:0]};
        return r;
    endfunction

    function automatic logic [15:0] status_word(input logic [1:0] op, input logic [7:0] data);
        stat_reply_t s;
        s.zero = 1'b0;
        s.op   = op;
        s.par  = 1'b0;
        s.st   = 2'b11;
        s.es   = 2'b10;
        s.data = data;
        return seal_parity(s);
    endfunction

    localparam logic [15:0] RESET_REPLY =
        status_word(OP_NONE, 8'((1 << EB_RE) | (1 << EB_DU)));

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= INIT;
            else if (i == 0)
                stage[i] <= d;
            else
                stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sfe_frame_io.sv
module sfe_frame_io
    import sfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_n_s,
    input  logic                  sck_s,
    input  logic                  mosi_s,
    input  logic [FRAME_BITS-1:0] load_word,
    output logic                  frame_end,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic [CNT_W-1:0]      edge_cnt,
    output logic [FRAME_BITS-1:0] tx_q,
    output logic                  miso
);
    logic sel_d, sck_d;
    logic frame_start, sck_rise, sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            sel_d <= sel_n_s;
            sck_d <= sck_s;
        end
    end

    assign frame_start = sel_d & ~sel_n_s;
    assign frame_end   = ~sel_d & sel_n_s;
    assign sck_rise    = ~sel_n_s & sck_s & ~sck_d;
    assign sck_fall    = ~sel_n_s & ~sck_s & sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= '0;
            rx_word  <= '0;
        end else if (frame_start) begin
            edge_cnt <= '0;
        end else if (sck_rise) begin
            rx_word <= {rx_word[FRAME_BITS-2:0], mosi_s};
            if (edge_cnt != CNT_W'(CNT_MAX))
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= RESET_REPLY;
        else if (frame_end)
            tx_q <= load_word;
        else if (sck_fall)
            tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
    end

    assign miso = ~sel_n_s & tx_q[FRAME_BITS-1];
endmodule

// File: rtl/sfe_reply.sv
module sfe_reply
    import sfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_end,
    input  logic [FRAME_BITS-1:0] rx_word,
    input  logic [CNT_W-1:0]      edge_cnt,
    input  logic [15:0]           x_word,
    input  logic [15:0]           y_word,
    input  logic                  pwr_down,
    input  logic                  heat_fault,
    output logic [FRAME_BITS-1:0] reply_word,
    output logic [7:0]            ctrl_q
);
    logic        frame_ok, is_sensor, ch_legal, do_write;
    op_e         op;
    logic [3:0]  ch;
    logic [15:0] axis;
    logic [7:0]  pick, fault_byte;
    sens_reply_t sr;

    assign frame_ok  = (edge_cnt == CNT_W'(FRAME_BITS));
    assign is_sensor = rx_word[13];
    assign op        = op_e'(rx_word[15:14]);
    assign ch        = rx_word[3:0];
    assign ch_legal  = (ch < 4'(NUM_CH));
    assign axis      = ch[1] ? y_word : x_word;
    assign pick      = ch[0] ? axis[15:8] : axis[7:0];
    assign do_write  = frame_ok & ~is_sensor & (op == OP_WR);

    always_comb begin
        fault_byte        = '0;
        fault_byte[EB_PD] = pwr_down;
        fault_byte[EB_HE] = heat_fault;
        sr.seq_hi = rx_word[15:14];
        sr.sen    = 1'b1;
        sr.par    = 1'b0;
        sr.seq_lo = rx_word[12];
        sr.ch     = ch[2:0];
        sr.data   = pick;
    end

    always_comb begin
        if (!frame_ok)
            reply_word = status_word(OP_NONE, 8'(1 << EB_SE));
        else if (is_sensor) begin
            if (!ch_legal)
                reply_word = status_word(op, 8'(1 << EB_RE));
            else if (pwr_down || heat_fault)
                reply_word = status_word(op, fault_byte);
            else
                reply_word = seal_parity(sr);
        end else begin
            unique case (op)
                OP_WR:   reply_word = status_word(op, rx_word[7:0]);
                OP_RD:   reply_word = status_word(op, ctrl_q);
                default: reply_word = status_word(op, 8'(1 << EB_RE));
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= 8'h00;
        else if (frame_end && do_write)
            ctrl_q <= rx_word[7:0];
    end
endmodule

// File: rtl/spi_sensor_frame.sv
module spi_sensor_frame
    import sfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_n,
    input  logic        sck,
    input  logic        mosi,
    input  logic [15:0] x_word,
    input  logic [15:0] y_word,
    input  logic        pwr_down,
    input  logic        heat_fault,
    output logic        miso,
    output logic [7:0]  ctrl_reg
);
    logic [2:0]            pins_s;
    logic                  sel_n_s, sck_s, mosi_s;
    logic                  frame_end;
    logic [FRAME_BITS-1:0] rx_word, reply_word, tx_q;
    logic [CNT_W-1:0]      edge_cnt;

    sfe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n, sck, mosi}),
        .q   (pins_s)
    );

    assign sel_n_s = pins_s[2];
    assign sck_s   = pins_s[1];
    assign mosi_s  = pins_s[0];

    sfe_frame_io u_io (
        .clk       (clk),
        .rst       (rst),
        .sel_n_s   (sel_n_s),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .load_word (reply_word),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .edge_cnt  (edge_cnt),
        .tx_q      (tx_q),
        .miso      (miso)
    );

    sfe_reply u_reply (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .rx_word    (rx_word),
        .edge_cnt   (edge_cnt),
        .x_word     (x_word),
        .y_word     (y_word),
        .pwr_down   (pwr_down),
        .heat_fault (heat_fault),
        .reply_word (reply_word),
        .ctrl_q     (ctrl_reg)
    );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
    import sfe_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  sel_n_s,
    input logic                  frame_end,
    input logic [CNT_W-1:0]      edge_cnt,
    input logic [FRAME_BITS-1:0] rx_word,
    input logic [FRAME_BITS-1:0] tx_q,
    input logic [7:0]            ctrl_reg,
    input logic                  miso
);
    p_idle_miso_r1: assert property (@(posedge clk) disable iff (rst)
        sel_n_s |-> !miso);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= CNT_W'(CNT_MAX));

    p_odd_load_r5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> ($countones(tx_q) % 2 == 1));

    p_ctrl_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(ctrl_reg));

    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_end && edge_cnt == CNT_W'(FRAME_BITS) && !rx_word[13]
         && (rx_word[15:14] == 2'b00 || rx_word[15:14] == 2'b11))
        |=> ($stable(ctrl_reg) && tx_q[7:0] == 8'h02));

    p_bad_count_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_end && edge_cnt != CNT_W'(FRAME_BITS))
        |=> ($stable(ctrl_reg) && tx_q == status_word(OP_NONE, 8'h04)));
endmodule

bind spi_sensor_frame sfe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_n_s   (sel_n_s),
    .frame_end (frame_end),
    .edge_cnt  (edge_cnt),
    .rx_word   (rx_word),
    .tx_q      (tx_q),
    .ctrl_reg  (ctrl_reg),
    .miso      (miso)
);

// File: tb/tb_spi_sensor_frame.sv
module tb_spi_sensor_frame;
    localparam int H = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [15:0] x_word = '0, y_word = '0;
    logic        pwr_down = 1'b0, heat_fault = 1'b0;
    logic        miso;
    logic [7:0]  ctrl_reg;

    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] exp_rep;
    string       exp_tag;
    logic [7:0]  mctrl;

    always #2 clk = ~clk;

    spi_sensor_frame dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .mosi(mosi),
        .x_word(x_word), .y_word(y_word), .pwr_down(pwr_down),
        .heat_fault(heat_fault), .miso(miso), .ctrl_reg(ctrl_reg)
    );

    function automatic logic [15:0] seal(input logic [15:0] w);
        logic [15:0] r = w;
        r[12] = ((($countones({w[15:13], w[11:0]})) % 2) == 0);
        return r;
    endfunction

    function automatic logic [15:0] stat(input logic [1:0] op, input logic [7:0] d);
        return seal({1'b0, op, 1'b0, 2'b11, 2'b10, d});
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected reply for the frame just sent, per the requirements
    task automatic model(input logic [15:0] w, input int n);
        logic [15:0] ax;
        logic [7:0]  b;
        if (n != 16) begin
            exp_rep = stat(2'b00, 8'h04); exp_tag = "R10";
        end else if (w[13]) begin
            if (w[3:0] > 4'd3) begin
                exp_rep = stat(w[15:14], 8'h02); exp_tag = "R9";
            end else if (pwr_down || heat_fault) begin
                exp_rep = stat(w[15:14], {3'b0, pwr_down, heat_fault, 3'b0}); exp_tag = "R11";
            end else begin
                ax = w[1] ? y_word : x_word;
                b  = w[0] ? ax[15:8] : ax[7:0];
                exp_rep = seal({w[15:14], 1'b1, 1'b0, w[12], w[2:0], b}); exp_tag = "R6";
            end
        end else begin
            case (w[15:14])
                2'b01: begin mctrl = w[7:0]; exp_rep = stat(2'b01, w[7:0]); exp_tag = "R7"; end
                2'b10: begin exp_rep = stat(2'b10, mctrl); exp_tag = "R8"; end
                default: begin exp_rep = stat(w[15:14], 8'h02); exp_tag = "R9"; end
            endcase
        end
    endtask

    // R1/R2: one frame; checks the reply to the previous request
    task automatic run(input logic [15:0] w, input int n);
        logic [15:0] got = '0;
        sel_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(H);
            if (i < 16) got[15-i] = miso;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
        wait_clk(H);
        sel_n = 1'b1;
        wait_clk(3 * H);
        if (n == 16) check({exp_tag, " R2 R4 R5"}, got, exp_rep);
        model(w, n);
        check({exp_tag, " ctrl"}, {8'h00, ctrl_reg}, {8'h00, mctrl});
        check("R1 idle miso", {15'h0, miso}, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        mctrl   = 8'h00;
        exp_rep = 16'h0E03;
        exp_tag = "R3";
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        check("R12 reset ctrl", {8'h00, ctrl_reg}, 16'h0000);
        check("R1 reset miso", {15'h0, miso}, 16'h0);

        // R3 first reply, then R6/R9 channel sweep
        for (int c = 0; c < 16; c++) begin
            x_word = 16'h1234 + 16'(c) * 16'h1111;
            y_word = ~x_word ^ 16'h0F0F;
            run({2'(c), 1'b1, 1'(c >> 2), 8'(c * 29), 4'(c)}, 16);
        end
        // R11 faults
        for (int f = 0; f < 4; f++) begin
            pwr_down = f[0]; heat_fault = f[1];
            run({2'b10, 1'b1, 1'b0, 8'hC3, 4'(f)}, 16);
        end
        pwr_down = 1'b0; heat_fault = 1'b0;
        // R7/R8 write then read back
        for (int v = 0; v < 16; v++) begin
            run({2'b01, 1'b0, 5'(v * 7), 8'(v * 17) ^ 8'hA5}, 16);
            run({2'b10, 1'b0, 5'(v), 8'(~v)}, 16);
        end
        // R9 illegal opcodes leave ctrl alone
        run({2'b00, 1'b0, 5'h1F, 8'h5A}, 16);
        run({2'b11, 1'b0, 5'h00, 8'hFF}, 16);
        run({2'b10, 1'b0, 13'h0}, 16);
        // R10 bad edge counts
        run({2'b01, 1'b0, 5'h0, 8'h3C}, 15);
        run({2'b10, 1'b0, 13'h0}, 16);
        run({2'b01, 1'b0, 5'h0, 8'h3C}, 17);
        run({2'b10, 1'b0, 13'h0}, 16);
        run(16'h0, 0);
        run({2'b10, 1'b0, 13'h0}, 16);
        run({2'b10, 1'b0, 13'h0}, 16);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule